// File: doc/BRIEF.md
# Continuous-Mode Clocked Serial Transceiver

This block is a synchronous serial master that moves 8-bit words out on a data-out line and in on a data-in line, in step with a serial clock it generates itself. Software loads a first word into a holding register and a second into the transmit buffer, then issues a start command. The block then runs both words back to back. After each word it raises a one-cycle completion pulse. The sequence keeps going for as long as software refills the transmit buffer soon enough.

The refill deadline is the reservation window. It runs from the completion pulse of a word to the point where the next word's first clock edge would occur, which is half a serial clock period later. When a queued word exists at that point, the next word starts with no idle gap, and the word just received moves from the shift register into the receive buffer. When no word is queued, the sequence ends. The final received word then stays in the shift register, and software reads it there.

Top module: `serial_chain_master`

## Requirements
- R1: After a synchronous active-low reset the serial clock is high, data-out is low, the completion pulse is low, and reads of addresses 0, 1 and 2 all return 0.
- R2: Each word is sent MSB first. The data-out line changes only in the cycle in which the serial clock falls.
- R3: Data-in is sampled on each serial clock rising edge. The first sampled bit of a word ends up as the MSB of the received word.
- R4: A write of 1 to bit 0 of address 2 while idle starts a sequence. It sets two requests at once: word 1 comes from the holding register (written at address 0) and word 2 from the transmit buffer (written at address 1). The two words run with no idle gap, so every serial clock period inside a sequence is exactly 2*HALF_CYC system cycles.
- R5: The completion pulse is high for exactly one cycle per word, in the cycle in which the serial clock makes its eighth rise.
- R6: A transmit-buffer write accepted before a word's reservation window closes queues one more word. The window closes HALF_CYC cycles after the completion pulse, and a write in the last cycle of the window still counts. The queued word follows without a gap, and the receive buffer (read at address 0) then takes the word just received.
- R7: When the window closes with nothing queued, the sequence ends and the receive buffer keeps its old value. Address 1 then reads the final received word from the shift register.
- R8: The busy bit (bit 0 of address 2) reads 1 from the cycle after the start write until the window of the last word closes, and 0 after that.
- R9: A transmit-buffer write while a request is still pending is ignored and sets the sticky overrun bit (bit 1 of address 2). Writing 1 to bit 1 of address 2 clears that bit.
- R10: The serial clock idles high whenever the block is not busy.
- R11: A start command issued while busy has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address (0 data/hold, 1 transmit/shift, 2 control/status) |
| busWrData | input | 8 | Register write data |
| busRdData | output | 8 | Register read data, combinational from busAddr |
| sck | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| doneIrq | output | 1 | One-cycle pulse per completed word |

## Verification
The start write takes effect at the clock edge on which it is presented. At that edge the serial clock falls and the first data bit appears. Falls then follow every 2*HALF_CYC cycles. The completion pulse arrives 15*HALF_CYC cycles after the word begins, and the window closes HALF_CYC cycles after the pulse. The bench therefore times every fall against a running cycle count. It samples busy once in the pulse cycle and again exactly HALF_CYC cycles later. In late-refill runs, it places its refill write on the edge that closes the window. Register reads are combinational, so each read is checked one nanosecond after the address is set at a falling system-clock edge.

// File: rtl/scm_pkg.sv
package scm_pkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_TX   = 2'd1;
  localparam logic [1:0] ADDR_CTL  = 2'd2;

  typedef struct packed {
    logic holdWr;      // store bus data as first word
    logic txWr;        // store bus data in transmit buffer
    logic loadFirst;   // shift register takes holding word
    logic loadNext;    // chain: shift takes next word, rx buffer takes shift
    logic nextFromBus; // next word comes straight from the bus write
    logic shiftIn;     // rising serial edge
    logic shiftOut;    // falling serial edge inside a word
  } dpStrobe_t;
endpackage

// File: rtl/scm_ctrl.sv
module scm_ctrl
  import scm_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWrEn,
  input  logic [1:0] busAddr,
  input  logic [1:0] ctlBits,
  output dpStrobe_t  strobe,
  output logic       sck,
  output logic       busy,
  output logic       doneIrq,
  output logic       overrun
);
  localparam int CNT_W = $clog2(HALF_CYC + 1);
  localparam int BIT_W = $clog2(DATA_W);

  logic [CNT_W-1:0] phaseCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             reqPend;

  logic wrTx, wrHold, wrCtl, startReq, txAccept, txReject, grab;
  logic phaseEnd, lastBit, riseNow, fallMid, windowEnd, chainNow;

  always_comb begin
    wrTx      = busWrEn && (busAddr == ADDR_TX);
    wrHold    = busWrEn && (busAddr == ADDR_DATA);
    wrCtl     = busWrEn && (busAddr == ADDR_CTL);
    startReq  = wrCtl && ctlBits[0] && !busy;
    txAccept  = wrTx && (!busy || !reqPend);
    txReject  = wrTx && busy && reqPend;
    grab      = txAccept && busy;
    phaseEnd  = busy && (phaseCnt == CNT_W'(HALF_CYC - 1));
    lastBit   = (bitCnt == BIT_W'(DATA_W - 1));
    riseNow   = phaseEnd && !sck;
    fallMid   = phaseEnd && sck && !lastBit;
    windowEnd = phaseEnd && sck && lastBit;
    chainNow  = windowEnd && (reqPend || grab);

    strobe.holdWr      = wrHold;
    strobe.txWr        = txAccept;
    strobe.loadFirst   = startReq;
    strobe.loadNext    = chainNow;
    strobe.nextFromBus = !reqPend;
    strobe.shiftIn     = riseNow;
    strobe.shiftOut    = fallMid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      sck      <= 1'b1;
      phaseCnt <= '0;
      bitCnt   <= '0;
      reqPend  <= 1'b0;
      doneIrq  <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      doneIrq <= riseNow && lastBit;

      if (txReject)                  overrun <= 1'b1;
      else if (wrCtl && ctlBits[1])  overrun <= 1'b0;

      if (startReq)      reqPend <= 1'b1;   // two set, first retired at once
      else if (chainNow) reqPend <= 1'b0;
      else if (grab)     reqPend <= 1'b1;

      if (startReq) begin
        busy     <= 1'b1;
        sck      <= 1'b0;
        phaseCnt <= '0;
        bitCnt   <= '0;
      end else if (phaseEnd) begin
        phaseCnt <= '0;
        if (riseNow) begin
          sck <= 1'b1;
        end else if (fallMid) begin
          sck    <= 1'b0;
          bitCnt <= bitCnt + BIT_W'(1);
        end else if (chainNow) begin
          sck    <= 1'b0;
          bitCnt <= '0;
        end else begin
          busy   <= 1'b0;
          bitCnt <= '0;
        end
      end else if (busy) begin
        phaseCnt <= phaseCnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/scm_datapath.sv
module scm_datapath
  import scm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              sdi,
  input  logic              busy,
  input  logic              overrun,
  output logic [DATA_W-1:0] busRdData,
  output logic              sdo
);
  logic [DATA_W-1:0] holdReg, txBuf, shiftReg, rxBuf, nextWord;

  assign nextWord = strobe.nextFromBus ? busWrData : txBuf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg  <= '0;
      txBuf    <= '0;
      shiftReg <= '0;
      rxBuf    <= '0;
      sdo      <= 1'b0;
    end else begin
      if (strobe.holdWr) holdReg <= busWrData;
      if (strobe.txWr)   txBuf   <= busWrData;
      if (strobe.loadFirst) begin
        shiftReg <= holdReg;
        sdo      <= holdReg[DATA_W-1];
      end else if (strobe.loadNext) begin
        rxBuf    <= shiftReg;
        shiftReg <= nextWord;
        sdo      <= nextWord[DATA_W-1];
      end else if (strobe.shiftIn) begin
        shiftReg <= {shiftReg[DATA_W-2:0], sdi};
      end else if (strobe.shiftOut) begin
        sdo <= shiftReg[DATA_W-1];
      end
    end
  end

  always_comb begin
    case (busAddr)
      ADDR_DATA: busRdData = rxBuf;
      ADDR_TX:   busRdData = shiftReg;
      ADDR_CTL:  busRdData = {{(DATA_W-2){1'b0}}, overrun, busy};
      default:   busRdData = '0;
    endcase
  end
endmodule

// File: rtl/serial_chain_master.sv
module serial_chain_master
  import scm_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              sck,
  output logic              sdo,
  input  logic              sdi,
  output logic              doneIrq
);
  dpStrobe_t strobe;
  logic      busyFlag;
  logic      overrunFlag;

  scm_ctrl #(.DATA_W(DATA_W), .HALF_CYC(HALF_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .ctlBits(busWrData[1:0]), .strobe(strobe), .sck(sck),
    .busy(busyFlag), .doneIrq(doneIrq), .overrun(overrunFlag)
  );

  scm_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .busWrData(busWrData), .sdi(sdi), .busy(busyFlag),
    .overrun(overrunFlag), .busRdData(busRdData), .sdo(sdo)
  );
endmodule

// File: rtl/scm_checker.sv
module scm_checker (
  input logic clk,
  input logic rstN,
  input logic sck,
  input logic sdo,
  input logic doneIrq,
  input logic busy,
  input logic overrun,
  input logic txWr,
  input logic clrWr
);
  // R5
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);
  // R5
  irq_at_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> $rose(sck));
  // R2
  sdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdo) |-> $fell(sck));
  // R10
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sck);
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !sck);
  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(txWr));
  // R9
  overrun_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(overrun) |-> $past(clrWr));
endmodule

bind serial_chain_master scm_checker chk_i (
  .clk(clk), .rstN(rstN), .sck(sck), .sdo(sdo), .doneIrq(doneIrq),
  .busy(busyFlag), .overrun(overrunFlag),
  .txWr(busWrEn && (busAddr == 2'd1)),
  .clrWr(busWrEn && (busAddr == 2'd2) && busWrData[1])
);

// File: tb/serial_chain_master_tb.sv
module serial_chain_master_tb_top;
  localparam int H = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWrEn = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWrData = 8'd0;
  logic [7:0] busRdData;
  logic       sck, sdo, doneIrq;
  logic       sdi = 1'b0;

  int total = 0, bad = 0;
  int cyc = 0, irqCnt = 0, riseCnt = 0, fallCnt = 0, gapBad = 0, lastFall = -1;
  int pulseBad = 0, curSeed = 0;
  logic prevIrq = 1'b0;
  logic [7:0] mosiW [0:7];

  always #2 clk = ~clk;

  serial_chain_master #(.DATA_W(8), .HALF_CYC(H)) dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .sck(sck), .sdo(sdo),
    .sdi(sdi), .doneIrq(doneIrq)
  );

  function automatic logic [7:0] txw(int seed, int k);
    return 8'((seed * 53 + k * 29 + 163) & 255);
  endfunction
  function automatic logic [7:0] misoW(int seed, int k);
    return 8'((seed * 37 + k * 91 + 5) & 255);
  endfunction

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (doneIrq) irqCnt = irqCnt + 1;
    if (doneIrq && prevIrq) pulseBad = pulseBad + 1;
    prevIrq = doneIrq;
  end

  // slave model: present next bit after each fall, collect data-out on rise
  always @(negedge sck) begin
    if (rstN) begin
      if (lastFall >= 0 && (cyc - lastFall) != 2 * H) gapBad = gapBad + 1;
      lastFall = cyc;
      fallCnt = fallCnt + 1;
      #1;
      sdi = misoW(curSeed, riseCnt / 8)[7 - (riseCnt % 8)];
    end
  end
  always @(posedge sck) begin
    if (rstN && riseCnt < 64) begin
      mosiW[riseCnt / 8][7 - (riseCnt % 8)] = sdo;
      riseCnt = riseCnt + 1;
    end
  end

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic busWr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string what);
    busAddr = a;
    #1;
    check(busRdData, exp, what);
  endtask

  // mode 0 plain, 1 extra start while busy (R11), 2 overrun write (R9)
  task automatic runSeq(input int L, input int seed, input bit late, input int mode);
    curSeed = seed; riseCnt = 0; irqCnt = 0; fallCnt = 0; gapBad = 0; lastFall = -1;
    busWr(0, txw(seed, 0));
    busWr(1, txw(seed, 1));
    busWr(2, 8'h01);
    @(negedge clk);
    rd(2, 8'h01, "R8 busy after start");
    if (mode == 1) busWr(2, 8'h01);
    if (mode == 2) begin
      busWr(1, 8'hEE);
      @(negedge clk);
      rd(2, 8'h03, "R9 overrun set");
    end
    for (int k = 2; k < L; k++) begin
      if (late) wait (irqCnt == k);
      else begin
        wait (irqCnt == k - 1);
        repeat (H + 2) @(negedge clk);
      end
      busWr(1, txw(seed, k));
    end
    @(negedge clk);
    while (!(doneIrq && irqCnt == L - 1)) @(negedge clk);
    rd(2, (mode == 2) ? 8'h03 : 8'h01, "R8 busy in last pulse");
    repeat (H) @(negedge clk);
    rd(2, (mode == 2) ? 8'h02 : 8'h00, "R8 busy clear at window end");
    check(8'(irqCnt), 8'(L), "R5 pulse count");
    check(8'(fallCnt), 8'(8 * L), "R6 fall count");
    check(8'(gapBad), 8'd0, "R4 gapless clock");
    check(sck, 1'b1, "R10 idle high");
    for (int k = 0; k < L; k++)
      check(mosiW[k], txw(seed, k), $sformatf("R2 word %0d sent", k));
    rd(1, misoW(seed, L - 1), "R7 final word in shift register");
    rd(0, misoW(seed, L - 2), "R6 receive buffer holds previous word");
    if (mode == 2) begin
      busWr(2, 8'h02);
      @(negedge clk);
      rd(2, 8'h00, "R9 overrun cleared");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sck, 1'b1, "R1 sck reset");
    check(sdo, 1'b0, "R1 sdo reset");
    check(doneIrq, 1'b0, "R1 irq reset");
    rd(0, 8'h00, "R1 rx reset");
    rd(1, 8'h00, "R1 shift reset");
    rd(2, 8'h00, "R1 status reset");
    rstN = 1'b1;
    for (int L = 2; L <= 5; L++)
      for (int late = 0; late < 2; late++)
        runSeq(L, L * 7 + late, late[0], 0);
    runSeq(3, 11, 1'b0, 1);   // R11
    runSeq(2, 9, 1'b0, 2);    // R9
    runSeq(4, 21, 1'b1, 2);   // R9 with chaining, R3 pattern variant
    check(8'(pulseBad), 8'd0, "R5 single-cycle pulse");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule